// File: doc/BRIEF.md
# USB Endpoint Receive Error Handler

This block serves one receive endpoint. It sits between a packet receiver, which delivers decoded bytes and end-of-packet indications, and a buffer manager, which supplies empty buffers and accepts the bytes that are written into them. Incoming bytes pass through a small receive FIFO into the open buffer. At the end of each packet the block decides whether the buffer is closed. A closing reports the byte count and a set of status flags. The block also decides which handshake goes back to the host.

Four error classes are detected: FIFO overrun, a packet that arrives with no buffer to hold it, a packet that ends on a non-byte boundary, and a bad CRC. Each class has its own buffer behaviour and its own handshake. In isochronous mode a CRC error is reported through an event bit, but the buffer stays open and the next packet appends to it. Sticky event bits summarise what happened, and they are cleared by a write-one-to-clear pulse.

A packet is framed by a one-cycle `pkt_start` and a one-cycle `pkt_end`. No byte is presented in the same cycle as `pkt_end`, and the next packet starts only after the previous buffer decision has been made.

Top module: `usb_rx_err_handler`

## Requirements
- R1: The receive FIFO holds 16 bytes. It presents them on `wr_byte` in arrival order, with `wr_valid` high whenever it is non-empty. A byte leaves the FIFO in each cycle in which `wr_valid` and `wr_ready` are both high. The close count equals the number of bytes written to the buffer.
- R2: A byte that arrives while the FIFO is full and nothing drains in that cycle overwrites the most recently stored byte. The remaining bytes of that packet are dropped. The buffer closes with the overrun flag (`close_stat` bit 0), and event bit 0 (buffer event) is set.
- R3: A `pkt_start` with no buffer open and `buf_avail` low discards the whole packet. There is no `buf_take`, no byte is written and the buffer is not closed. Event bit 1 (busy) is set.
- R4: A packet ending with `pkt_aligned` low still has its bytes written. The buffer closes with the misalignment flag (`close_stat` bit 1), and event bit 0 is set.
- R5: Outside isochronous mode, a packet ending with `pkt_crc_ok` low closes the buffer with the CRC flag (`close_stat` bit 2), and event bit 0 is set.
- R6: With `xfer_mode` equal to 2'b11 (isochronous), a CRC error sets event bit 2 but does not close the buffer. The next packet's bytes append to the same buffer and add to its count. No handshake is ever produced in this mode.
- R7: `hs_code` is 2'b01 (ACK) after a clean non-isochronous packet, and 2'b10 (NAK) after a packet that overran or was discarded for lack of a buffer. It is 2'b00 after CRC or alignment errors and in every other cycle. A non-zero code appears only in the single cycle after `pkt_end`.
- R8: When several errors hit one packet, the single close of that buffer carries every applicable flag.
- R9: Event bits are sticky. A bit is cleared only by a 1 on the matching `evt_clr` bit; a 1 on another bit leaves it unchanged.
- R10: `buf_take` pulses for one cycle at a `pkt_start` that finds no buffer open and `buf_avail` high. The byte count restarts at zero.
- R11: After reset, `wr_valid`, `buf_take`, `close_valid`, `hs_code` and `evt_flags` are all zero.
- R12: `close_valid` pulses for exactly one cycle, two cycles after `pkt_end` when the FIFO drains freely. A packet with no error closes with `close_stat` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_mode | input | 2 | Transfer mode; 2'b11 selects isochronous |
| pkt_start | input | 1 | One-cycle packet start |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| pkt_end | input | 1 | One-cycle end of packet |
| pkt_crc_ok | input | 1 | CRC check passed, sampled with pkt_end |
| pkt_aligned | input | 1 | Packet ended on a byte boundary, sampled with pkt_end |
| buf_avail | input | 1 | An empty buffer can be taken |
| buf_take | output | 1 | Pulse: take the next empty buffer |
| wr_valid | output | 1 | A byte is ready to be written to the buffer |
| wr_byte | output | 8 | Byte to be written |
| wr_ready | input | 1 | Buffer side accepts the byte |
| close_valid | output | 1 | Pulse: buffer closed |
| close_count | output | CNT_W | Bytes written to the closed buffer |
| close_stat | output | 3 | Flags: bit0 overrun, bit1 misaligned, bit2 CRC |
| hs_code | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK |
| evt_flags | output | 3 | Sticky events: bit0 buffer event, bit1 busy, bit2 isochronous CRC |
| evt_clr | input | 3 | Write-one-to-clear pulse for evt_flags |

## Verification
A wrong state bit inside the block shows up at the ports no later than the end of the packet it touches. A stuck overrun or drop flag shortens the run of bytes on `wr_byte` within the packet and changes `close_stat`. A lost end-of-packet marker leaves `close_valid` missing, two cycles after `pkt_end`. A wrong keep-open decision shifts the next `close_count`, because an isochronous buffer carries bytes across packets. Handshake and event faults appear in the cycle after `pkt_end` or after the clear pulse, so every check samples there.

// File: rtl/usb_rxe_pkg.sv
package usb_rxe_pkg;

  localparam logic [1:0] MODE_ISO = 2'b11;

  typedef enum logic [1:0] {
    HS_NONE = 2'b00,
    HS_ACK  = 2'b01,
    HS_NAK  = 2'b10
  } hs_e;

  // buffer status flags, bit order seen by the buffer manager
  typedef struct packed {
    logic crc;
    logic misalign;
    logic ovr;
  } bstat_t;

  // event bit positions
  localparam int EV_BUF  = 0;
  localparam int EV_BUSY = 1;
  localparam int EV_ISOC = 2;
  localparam int EV_N    = 3;

  function automatic hs_e hs_pick(input logic iso, input logic discard,
                                  input logic crc_ok, input logic aligned,
                                  input logic ovr);
    if (iso)                      return HS_NONE;
    else if (discard)             return HS_NAK;
    else if (!crc_ok || !aligned) return HS_NONE;
    else if (ovr)                 return HS_NAK;
    else                          return HS_ACK;
  endfunction

  // isochronous CRC error alone keeps the buffer open
  function automatic logic keep_open(input logic iso, input logic crc_ok,
                                     input logic aligned, input logic ovr);
    return iso && !crc_ok && aligned && !ovr;
  endfunction

endpackage

// File: rtl/rxe_fifo.sv
module rxe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         ovw
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          do_push;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] back(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign ovw     = push && full && !pop;
  assign do_push = push && !ovw;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (ovw)          mem[back(wr_ptr)] <= din;
    else if (do_push) mem[wr_ptr]       <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (pop)     rd_ptr <= bump(rd_ptr);
      case ({do_push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assert_fifo_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  assert_no_pop_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_ovw_stays_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovw |=> full);
endmodule

// File: rtl/rxe_events.sv
module rxe_events #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] evt
);
  always_ff @(posedge clk) begin
    if (!rst_n) evt <= '0;
    else        evt <= (evt & ~clr) | set;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_evt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && !clr[i]) |=> evt[i]);
    assert_evt_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !evt[i]);
  end
endmodule

// File: rtl/usb_rx_err_handler.sv
module usb_rx_err_handler
  import usb_rxe_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       xfer_mode,
  input  logic             pkt_start,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             pkt_end,
  input  logic             pkt_crc_ok,
  input  logic             pkt_aligned,
  input  logic             buf_avail,
  output logic             buf_take,
  output logic             wr_valid,
  output logic [7:0]       wr_byte,
  input  logic             wr_ready,
  output logic             close_valid,
  output logic [CNT_W-1:0] close_count,
  output logic [2:0]       close_stat,
  output logic [1:0]       hs_code,
  output logic [EV_N-1:0]  evt_flags,
  input  logic [EV_N-1:0]  evt_clr
);
  logic iso;
  logic in_pkt, discard, drop, buf_open, end_pend, keep_q;
  bstat_t flags;
  logic [CNT_W-1:0] cnt;
  hs_e hs_q;

  // named internal events
  logic start_ok, busy_start, push, pop, end_ok, close_fire, fifo_empty,
        fifo_full, fifo_ovw, rxb_set, isoc_set;
  logic [EV_N-1:0] ev_set;

  assign iso        = (xfer_mode == MODE_ISO);
  assign start_ok   = pkt_start && !in_pkt;
  assign buf_take   = start_ok && !buf_open && buf_avail;
  assign busy_start = start_ok && !buf_open && !buf_avail;
  assign push       = rx_valid && in_pkt && !discard && !drop;
  assign wr_valid   = !fifo_empty;
  assign pop        = wr_valid && wr_ready;
  assign end_ok     = pkt_end && in_pkt;
  assign close_fire = end_pend && fifo_empty;
  assign rxb_set    = close_fire && !keep_q && (|flags);
  assign isoc_set   = end_ok && !discard && iso && !pkt_crc_ok;

  always_comb begin
    ev_set          = '0;
    ev_set[EV_BUF]  = rxb_set;
    ev_set[EV_BUSY] = busy_start;
    ev_set[EV_ISOC] = isoc_set;
  end

  rxe_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(rx_byte), .pop(pop),
    .dout(wr_byte), .empty(fifo_empty), .full(fifo_full), .ovw(fifo_ovw)
  );

  rxe_events #(.N(EV_N)) u_evt (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(evt_clr), .evt(evt_flags)
  );

  // packet framing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      discard  <= 1'b0;
      drop     <= 1'b0;
      end_pend <= 1'b0;
      keep_q   <= 1'b0;
      hs_q     <= HS_NONE;
    end else begin
      if (start_ok) begin
        in_pkt  <= 1'b1;
        discard <= busy_start;
        drop    <= 1'b0;
      end else if (end_ok) begin
        in_pkt <= 1'b0;
      end
      if (fifo_ovw) drop <= 1'b1;
      hs_q <= end_ok ? hs_pick(iso, discard, pkt_crc_ok, pkt_aligned, flags.ovr)
                     : HS_NONE;
      if (end_ok && !discard) begin
        end_pend <= 1'b1;
        keep_q   <= keep_open(iso, pkt_crc_ok, pkt_aligned, flags.ovr);
      end else if (close_fire) begin
        end_pend <= 1'b0;
      end
    end
  end

  // buffer state, count and status flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_open    <= 1'b0;
      cnt         <= '0;
      flags       <= '0;
      close_valid <= 1'b0;
      close_count <= '0;
      close_stat  <= '0;
    end else begin
      close_valid <= 1'b0;
      if (buf_take) begin
        buf_open <= 1'b1;
        cnt      <= '0;
      end else if (pop) begin
        cnt <= cnt + 1'b1;
      end
      if (fifo_ovw) flags.ovr <= 1'b1;
      if (end_ok && !discard) begin
        if (!pkt_aligned)        flags.misalign <= 1'b1;
        if (!pkt_crc_ok && !iso) flags.crc      <= 1'b1;
      end
      if (close_fire && !keep_q) begin
        close_valid <= 1'b1;
        close_count <= cnt;
        close_stat  <= flags;
        buf_open    <= 1'b0;
        flags       <= '0;
      end
    end
  end

  assign hs_code = hs_q;

  assert_take_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_take |=> !buf_take);
  assert_hs_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code != HS_NONE) |-> $past(pkt_end));
  assert_iso_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code != HS_NONE) |-> ($past(xfer_mode) != MODE_ISO));
  assert_close_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid |=> !close_valid);
  assert_close_drained_R1: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid |-> !$past(wr_valid));
  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flags[EV_BUSY]) |-> ($past(pkt_start) && !$past(buf_avail)));
endmodule

// File: tb/sim_usb_rx_err_handler.sv
module sim_usb_rx_err_handler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] xfer_mode = 2'b00;
  logic       pkt_start = 1'b0, rx_valid = 1'b0, pkt_end = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       pkt_crc_ok = 1'b1, pkt_aligned = 1'b1, buf_avail = 1'b1;
  logic       wr_ready = 1'b1;
  logic [2:0] evt_clr = 3'b000;
  logic       buf_take, wr_valid, close_valid;
  logic [7:0] wr_byte;
  logic [10:0] close_count;
  logic [2:0] close_stat, evt_flags;
  logic [1:0] hs_code;

  always #10 clk = ~clk;

  usb_rx_err_handler u0 (
    .clk(clk), .rst_n(rst_n), .xfer_mode(xfer_mode), .pkt_start(pkt_start),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .pkt_end(pkt_end),
    .pkt_crc_ok(pkt_crc_ok), .pkt_aligned(pkt_aligned), .buf_avail(buf_avail),
    .buf_take(buf_take), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .wr_ready(wr_ready), .close_valid(close_valid), .close_count(close_count),
    .close_stat(close_stat), .hs_code(hs_code), .evt_flags(evt_flags),
    .evt_clr(evt_clr)
  );

  int n_chk = 0, n_fail = 0;
  int n_pop, n_close, n_take, n_hs, last_cnt, last_stat, last_hs;
  logic [7:0] popped [64];
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // port monitor: values seen just before each edge
  always @(posedge clk) begin
    cyc++;
    if (wr_valid && wr_ready) begin
      if (n_pop < 64) popped[n_pop] = wr_byte;
      n_pop++;
    end
    if (close_valid) begin
      n_close++;
      last_cnt  = int'(close_count);
      last_stat = int'(close_stat);
    end
    if (hs_code != 2'b00) begin
      n_hs++;
      last_hs = int'(hs_code);
    end
    if (buf_take) n_take++;
  end

  always @(posedge clk) begin
    if (!done && cyc > 200000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0] mode;
    logic [5:0] nb;
    logic       crc;
    logic       al;
    logic       av;
    logic       hold;
    logic       cls;
    logic [5:0] cnt;
    logic [2:0] fl;
    logic [1:0] hs;
    logic [2:0] ev;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 6'd5,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd5,  3'b000, 2'b01, 3'b000}, // R12 clean, ACK
    '{2'b00, 6'd20, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd16, 3'b001, 2'b10, 3'b001}, // R2 overrun
    '{2'b00, 6'd4,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'd4,  3'b100, 2'b00, 3'b001}, // R5 crc
    '{2'b00, 6'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd3,  3'b010, 2'b00, 3'b001}, // R4 misaligned
    '{2'b00, 6'd20, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd16, 3'b111, 2'b00, 3'b001}, // R8 all flags
    '{2'b00, 6'd6,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd0,  3'b000, 2'b10, 3'b010}, // R3 busy
    '{2'b11, 6'd4,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0,  3'b000, 2'b00, 3'b100}, // R6 iso crc
    '{2'b11, 6'd3,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'd7,  3'b000, 2'b00, 3'b000}, // R6 append
    '{2'b11, 6'd2,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd2,  3'b010, 2'b00, 3'b001}, // R4 iso
    '{2'b01, 6'd1,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd1,  3'b000, 2'b01, 3'b000}  // R7 bulk ACK
  };

  task automatic clear_mon();
    n_pop = 0; n_close = 0; n_take = 0; n_hs = 0;
    last_cnt = -1; last_stat = -1; last_hs = 0;
  endtask

  task automatic send_bytes(input int nb, input logic [7:0] base);
    for (int i = 0; i < nb; i++) begin
      rx_valid = 1'b1;
      rx_byte  = base + 8'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  bit bench_open = 0;

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(wr_valid == 0 && buf_take == 0 && close_valid == 0, "R11 outputs", int'(wr_valid), 0);
    chk(hs_code == 2'b00 && evt_flags == 3'b000, "R11 hs/evt", int'({hs_code, evt_flags}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_valid == 0 && evt_flags == 0, "R11 after release", int'(evt_flags), 0);

    for (int v = 0; v < NV; v++) begin
      automatic vec_t t = TBL[v];
      automatic logic [7:0] base = 8'(v * 32);
      automatic bit exp_take = !bench_open && t.av;
      automatic int exp_pop = (!bench_open && !t.av) ? 0 :
                              ((t.hold && t.nb > 16) ? 16 : int'(t.nb));
      xfer_mode = t.mode;
      buf_avail = t.av;
      wr_ready  = !t.hold;
      evt_clr   = 3'b111;
      @(negedge clk);
      evt_clr = 3'b000;
      clear_mon();
      pkt_start = 1'b1;
      @(negedge clk);
      pkt_start = 1'b0;
      send_bytes(int'(t.nb), base);
      pkt_crc_ok  = t.crc;
      pkt_aligned = t.al;
      pkt_end     = 1'b1;
      @(negedge clk);
      pkt_end  = 1'b0;
      wr_ready = 1'b1;
      repeat (40) @(negedge clk);

      chk(n_take == int'(exp_take), $sformatf("R10 vec%0d buf_take", v), n_take, int'(exp_take));
      chk(n_close == int'(t.cls), $sformatf("R12 vec%0d close pulses", v), n_close, int'(t.cls));
      if (t.cls) begin
        chk(last_cnt == int'(t.cnt), $sformatf("R1 vec%0d close count", v), last_cnt, int'(t.cnt));
        chk(last_stat == int'(t.fl), $sformatf("R8 vec%0d close flags", v), last_stat, int'(t.fl));
      end
      chk(last_hs == int'(t.hs) && n_hs <= 1, $sformatf("R7 vec%0d handshake", v), last_hs, int'(t.hs));
      chk(evt_flags == t.ev, $sformatf("R9 vec%0d events", v), int'(evt_flags), int'(t.ev));
      begin
        automatic bit data_ok = (n_pop == exp_pop);
        for (int i = 0; i < exp_pop && i < 64; i++) begin
          automatic logic [7:0] e = (t.hold && t.nb > 16 && i == 15) ? base + 8'd16
                                                                    : base + 8'(i);
          if (popped[i] != e) data_ok = 0;
        end
        chk(data_ok, $sformatf("R1 R2 vec%0d written bytes", v), n_pop, exp_pop);
      end
      if (t.cls) bench_open = 0;
      else if (exp_take) bench_open = 1;
    end

    // R7 / R12 exact timing on a clean packet
    xfer_mode = 2'b00; buf_avail = 1'b1; wr_ready = 1'b1;
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    send_bytes(2, 8'hA0);
    pkt_crc_ok = 1'b1; pkt_aligned = 1'b1; pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
    chk(hs_code == 2'b01, "R7 ACK in cycle after end", int'(hs_code), 1);
    chk(close_valid == 1'b0, "R12 no close one cycle after end", int'(close_valid), 0);
    @(negedge clk);
    chk(hs_code == 2'b00, "R7 handshake lasts one cycle", int'(hs_code), 0);
    chk(close_valid == 1'b1 && close_count == 11'd2 && close_stat == 3'b000,
        "R12 close two cycles after end", int'(close_count), 2);
    @(negedge clk);
    chk(close_valid == 1'b0, "R12 close is one cycle", int'(close_valid), 0);

    // R9 clear only the addressed bit; R3 bytes ignored while busy
    buf_avail = 1'b0;
    clear_mon();
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    send_bytes(3, 8'h55);
    pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_pop == 0 && wr_valid == 0, "R3 busy packet writes nothing", n_pop, 0);
    chk(evt_flags == 3'b010, "R3 busy event", int'(evt_flags), 2);
    evt_clr = 3'b101;
    @(negedge clk);
    evt_clr = 3'b000;
    @(negedge clk);
    chk(evt_flags == 3'b010, "R9 other clear bits leave busy set", int'(evt_flags), 2);
    evt_clr = 3'b010;
    @(negedge clk);
    evt_clr = 3'b000;
    chk(evt_flags == 3'b000, "R9 write-one clears busy", int'(evt_flags), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule